// File: doc/BRIEF.md
# Single DMA Channel with Instruction-Hold and Power-State Gating

This block is one DMA channel. It moves transfer units between a fixed peripheral-register address and an internal RAM pointer, in either direction. Software loads the channel with a direction, a unit width of 8 or 16 bits, a peripheral address, a starting RAM address and a unit count. Each trigger pulse asks for one unit. The request is latched and carried out over a simple single-cycle bus, in which read data returns in the same cycle as the read address and the write is issued in that same cycle.

A trigger is held back while any of three conditions holds: the CPU raises its instruction-hold input, the power state is STOP, or the channel is disabled. The hold input covers instructions after which a transfer may not begin, such as calls, software breaks and bit operations on interrupt-control registers. In the HALT power state, transfers run as usual. Entering STOP while the channel is enabled aborts the count.

Every RAM access is checked against a window that excludes the register bank and everything above it. An access outside the window either drops the RAM write or sends a filler value to the peripheral, and it sets an error flag.

Top module: `dma_hold_channel`

## Requirements
- R1: After reset, `busy`, `done_irq`, `err_flag`, `ovr_flag` and `abort_flag` are 0, and neither `bus_rd_en` nor `bus_wr_en` is asserted.
- R2: A trigger seen at a clock edge while the channel is unblocked causes one transfer unit in the following cycle. With `cfg_dir`=0 (peripheral to RAM), the read address is the peripheral address, the write address is the RAM pointer and the write data is the read data. With `cfg_dir`=1 (RAM to peripheral), the two addresses swap. In 8-bit mode, bits 15:8 of the write data are 0.
- R3: With `pwr_state`=1 (HALT), transfers behave exactly as with `pwr_state`=0 (RUN).
- R4: While `cpu_hold` is 1, neither `bus_rd_en` nor `bus_wr_en` is asserted. A request that is pending is carried out in the first cycle in which `cpu_hold` is 0.
- R5: The RAM pointer steps by 1 after each 8-bit unit and by 2 after each 16-bit unit. The peripheral address never changes.
- R6: After `cfg_count` units, `busy` falls and `done_irq` is 1 for exactly one cycle, the cycle after the last unit.
- R7: The RAM window runs from `RAM_LO` (default 0xFEF00) to 0xFFEDF. Every byte of the unit must lie inside it. In peripheral-to-RAM mode, a unit outside the window still reads but does not write (`bus_wr_en`=0), and `err_flag` is set in the next cycle.
- R8: In RAM-to-peripheral mode, a unit outside the window performs no read. It writes the filler 0xA5A5 to the peripheral, reduced to 0x00A5 in 8-bit mode, and sets `err_flag`.
- R9: With `pwr_state`=2 (STOP), no transfer takes place. If the channel is enabled when STOP is seen at a clock edge, `busy` clears and `abort_flag` sets, and `done_irq` does not pulse.
- R10: Only one request is latched while the channel is blocked. A trigger that arrives while a request is already pending under a blocking condition sets `ovr_flag`, and only one unit follows the release.
- R11: A `cfg_load` clears `err_flag`, `ovr_flag`, `abort_flag` and any pending request, and sets `busy` when `cfg_count` is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load configuration and arm the channel |
| cfg_dir | input | 1 | 0 = peripheral to RAM, 1 = RAM to peripheral |
| cfg_wide | input | 1 | 1 = 16-bit units, 0 = 8-bit units |
| cfg_sfr_addr | input | 20 | Fixed peripheral register address |
| cfg_ram_addr | input | 20 | Starting RAM address |
| cfg_count | input | 8 | Number of units to move |
| trig | input | 1 | Transfer request, one unit per pulse |
| cpu_hold | input | 1 | CPU instruction-class hold |
| pwr_state | input | 2 | 0 RUN, 1 HALT, 2 STOP |
| bus_rd_en | output | 1 | Read strobe |
| bus_rd_addr | output | 20 | Read address |
| bus_rd_data | input | 16 | Read data, valid in the same cycle |
| bus_wr_en | output | 1 | Write strobe |
| bus_wr_addr | output | 20 | Write address |
| bus_wr_data | output | 16 | Write data |
| bus_wide | output | 1 | Unit width of the current access |
| busy | output | 1 | Channel enabled with units remaining |
| done_irq | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | A unit fell outside the RAM window |
| ovr_flag | output | 1 | A trigger was lost while blocked |
| abort_flag | output | 1 | The count was cut short by STOP |

## Verification
A pending bit that is wrong shows up on the strobes within one cycle, either as a transfer inside a hold or STOP window or as a missing transfer after the release. An off-by-one in the pointer or the counter shows up on `bus_wr_addr` or `bus_rd_addr` of the next unit, or as `done_irq` arriving one unit early or late. A window check that is wrong changes `bus_wr_en` or the filler data in that same cycle, and `err_flag` one edge later.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_HALT = 2'd1,
    PWR_STOP = 2'd2
  } pwr_e;

  typedef enum logic {
    DIR_SFR2RAM = 1'b0,
    DIR_RAM2SFR = 1'b1
  } dir_e;
endpackage

// File: rtl/dmach_req.sv
module dmach_req (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  input  logic blocked,
  input  logic take,
  output logic pend,
  output logic ovr
);
  // one-deep request latch with sticky overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else if (clr) begin
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (trig && pend && blocked) ovr <= 1'b1;
      if (trig)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && pend && blocked && !clr) |=> ovr);

  a_r4_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend);
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr #(
  parameter int AW = 20,
  parameter logic [AW-1:0] RAM_LO = 20'hFEF00,
  parameter logic [AW-1:0] RAM_HI = 20'hFFEDF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          wide,
  output logic [AW-1:0] ptr,
  output logic          ok
);
  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] a, input logic w);
    return a + (w ? AW'(2) : AW'(1));
  endfunction

  function automatic logic win_ok(input logic [AW-1:0] a, input logic w);
    logic [AW-1:0] last;
    last = a + (w ? AW'(1) : AW'(0));
    return (a >= RAM_LO) && (last <= RAM_HI) && (last >= a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (step) ptr <= step_ptr(ptr, wide);
  end

  assign ok = win_ok(ptr, wide);

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((ptr - $past(ptr)) == ($past(wide) ? AW'(2) : AW'(1))));

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr));
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl #(
  parameter int AW = 20,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cfg_dir,
  input  logic          cfg_wide,
  input  logic [AW-1:0] cfg_sfr,
  input  logic [CW-1:0] cfg_count,
  input  logic          pend,
  input  logic          hold,
  input  logic          stop,
  input  logic          bad,
  output logic          en,
  output logic          go,
  output logic          dir_q,
  output logic          wide_q,
  output logic [AW-1:0] sfr_q,
  output logic          done,
  output logic          abt,
  output logic          err
);
  logic [CW-1:0] cnt;
  logic          last_unit;

  assign go        = pend && en && !hold && !stop;
  assign last_unit = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; cnt <= '0; done <= 1'b0; abt <= 1'b0; err <= 1'b0;
      dir_q <= 1'b0; wide_q <= 1'b0; sfr_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        en     <= (cfg_count != '0);
        cnt    <= cfg_count;
        dir_q  <= cfg_dir;
        wide_q <= cfg_wide;
        sfr_q  <= cfg_sfr;
        abt    <= 1'b0;
        err    <= 1'b0;
      end else if (en && stop) begin
        en  <= 1'b0;
        abt <= 1'b1;
      end else if (go) begin
        cnt <= cnt - CW'(1);
        if (bad) err <= 1'b1;
        if (last_unit) begin
          en   <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !en);

  a_r9_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop && !load) |=> (!en && abt && !done));

  a_r9_no_go_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !go);
endmodule

// File: rtl/dma_hold_channel.sv
module dma_hold_channel #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] RAM_LO = 20'hFEF00,
  parameter logic [AW-1:0] RAM_HI = 20'hFFEDF,
  parameter logic [DW-1:0] FILL   = 16'hA5A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_dir,
  input  logic          cfg_wide,
  input  logic [AW-1:0] cfg_sfr_addr,
  input  logic [AW-1:0] cfg_ram_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          trig,
  input  logic          cpu_hold,
  input  logic [1:0]    pwr_state,
  output logic          bus_rd_en,
  output logic [AW-1:0] bus_rd_addr,
  input  logic [DW-1:0] bus_rd_data,
  output logic          bus_wr_en,
  output logic [AW-1:0] bus_wr_addr,
  output logic [DW-1:0] bus_wr_data,
  output logic          bus_wide,
  output logic          busy,
  output logic          done_irq,
  output logic          err_flag,
  output logic          ovr_flag,
  output logic          abort_flag
);
  import dmach_pkg::*;

  localparam int HW = DW / 2;

  logic          stop_w, en_w, go_w, pend_w, blocked_w, ok_w, bad_w;
  logic          dir_w, wide_w;
  logic [AW-1:0] sfr_w, ptr_w;
  logic [DW-1:0] raw_w;

  assign stop_w    = (pwr_state == PWR_STOP);
  assign blocked_w = cpu_hold || stop_w || !en_w;
  assign bad_w     = !ok_w;

  dmach_req u_req (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .trig(trig),
    .blocked(blocked_w), .take(go_w), .pend(pend_w), .ovr(ovr_flag)
  );

  dmach_addr #(.AW(AW), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_addr(cfg_ram_addr),
    .step(go_w), .wide(wide_w), .ptr(ptr_w), .ok(ok_w)
  );

  dmach_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .cfg_dir(cfg_dir),
    .cfg_wide(cfg_wide), .cfg_sfr(cfg_sfr_addr), .cfg_count(cfg_count),
    .pend(pend_w), .hold(cpu_hold), .stop(stop_w), .bad(bad_w),
    .en(en_w), .go(go_w), .dir_q(dir_w), .wide_q(wide_w), .sfr_q(sfr_w),
    .done(done_irq), .abt(abort_flag), .err(err_flag)
  );

  // bus steering: RAM-side read is suppressed for an out-of-window source
  assign bus_rd_en   = go_w && !(dir_w == DIR_RAM2SFR && bad_w);
  assign bus_rd_addr = (dir_w == DIR_RAM2SFR) ? ptr_w : sfr_w;
  assign bus_wr_en   = go_w && ((dir_w == DIR_RAM2SFR) || ok_w);
  assign bus_wr_addr = (dir_w == DIR_RAM2SFR) ? sfr_w : ptr_w;
  assign raw_w       = (dir_w == DIR_RAM2SFR && bad_w) ? FILL : bus_rd_data;
  assign bus_wr_data = wide_w ? raw_w : {{HW{1'b0}}, raw_w[HW-1:0]};
  assign bus_wide    = wide_w;
  assign busy        = en_w;

  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> (!bus_rd_en && !bus_wr_en));

  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |-> (!bus_rd_en && !bus_wr_en));

  a_r7_drop_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && dir_w == DIR_SFR2RAM && !ok_w) |-> !bus_wr_en);

  a_r7_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (go_w && !ok_w && !cfg_load) |=> err_flag);

  a_r8_fill_to_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && dir_w == DIR_RAM2SFR && !ok_w) |-> (bus_wr_data[HW-1:0] == FILL[HW-1:0]));
endmodule

// File: tb/sim_dma_hold_channel.sv
module sim_dma_hold_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_dir = 1'b0, cfg_wide = 1'b0;
  logic [19:0] cfg_sfr_addr = '0, cfg_ram_addr = '0;
  logic [7:0]  cfg_count = '0;
  logic        trig = 1'b0, cpu_hold = 1'b0;
  logic [1:0]  pwr_state = 2'd0;
  logic        bus_rd_en, bus_wr_en, bus_wide;
  logic [19:0] bus_rd_addr, bus_wr_addr;
  logic [15:0] bus_rd_data, bus_wr_data;
  logic        busy, done_irq, err_flag, ovr_flag, abort_flag;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_val(input logic [19:0] a);
    return {a[15:8] + 8'h11, a[7:0] ^ 8'h3C};
  endfunction

  assign bus_rd_data = mem_val(bus_rd_addr);

  dma_hold_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_dir(cfg_dir),
    .cfg_wide(cfg_wide), .cfg_sfr_addr(cfg_sfr_addr), .cfg_ram_addr(cfg_ram_addr),
    .cfg_count(cfg_count), .trig(trig), .cpu_hold(cpu_hold), .pwr_state(pwr_state),
    .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
    .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .bus_wide(bus_wide), .busy(busy), .done_irq(done_irq), .err_flag(err_flag),
    .ovr_flag(ovr_flag), .abort_flag(abort_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic load(input logic dir, input logic wide, input logic [19:0] sfr,
                      input logic [19:0] ram, input logic [7:0] cnt);
    cfg_load = 1'b1; cfg_dir = dir; cfg_wide = wide;
    cfg_sfr_addr = sfr; cfg_ram_addr = ram; cfg_count = cnt;
    step();
    cfg_load = 1'b0;
  endtask

  // trigger one cycle; on return the unit (if unblocked) is on the bus
  task automatic pulse();
    trig = 1'b1;
    step();
    trig = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 rd_en", bus_rd_en, 0);
    check("R1 wr_en", bus_wr_en, 0);
    check("R1 flags", {done_irq, err_flag, ovr_flag, abort_flag}, 0);
  endtask

  task automatic t_byte_s2r();
    load(1'b0, 1'b0, 20'hFFF10, 20'hFF000, 8'd3);
    check("R11 busy after load", busy, 1);
    for (int i = 0; i < 3; i++) begin
      pulse();
      check("R2 rd_en", bus_rd_en, 1);
      check("R5 sfr fixed", bus_rd_addr, 20'hFFF10);
      check("R2 wr_en", bus_wr_en, 1);
      check("R5 ram step 1", bus_wr_addr, 20'hFF000 + i);
      check("R2 byte data", bus_wr_data, {8'h00, mem_val(20'hFFF10) & 16'h00FF});
      check("R6 no early done", done_irq, 0);
      step();
    end
    check("R6 done pulse", done_irq, 1);
    check("R6 busy drops", busy, 0);
    step();
    check("R6 done one cycle", done_irq, 0);
  endtask

  task automatic t_word_r2s();
    load(1'b1, 1'b1, 20'hFFF20, 20'hFF100, 8'd2);
    for (int i = 0; i < 2; i++) begin
      pulse();
      check("R5 ram step 2", bus_rd_addr, 20'hFF100 + 2 * i);
      check("R2 wr to sfr", bus_wr_addr, 20'hFFF20);
      check("R2 word data", bus_wr_data, mem_val(20'hFF100 + 2 * i));
      check("R2 wide", bus_wide, 1);
      step();
    end
    check("R6 done word", done_irq, 1);
  endtask

  task automatic t_halt();
    pwr_state = 2'd1;
    load(1'b0, 1'b0, 20'hFFF30, 20'hFF200, 8'd1);
    pulse();
    check("R3 halt transfers", bus_wr_en, 1);
    check("R3 halt addr", bus_wr_addr, 20'hFF200);
    step();
    check("R3 halt done", done_irq, 1);
    pwr_state = 2'd0;
  endtask

  task automatic t_hold();
    load(1'b0, 1'b0, 20'hFFF10, 20'hFF300, 8'd2);
    cpu_hold = 1'b1;
    pulse();
    check("R4 held rd", bus_rd_en, 0);
    check("R4 held wr", bus_wr_en, 0);
    step(); step();
    check("R4 still held", bus_wr_en, 0);
    check("R10 no ovr yet", ovr_flag, 0);
    pulse();
    check("R10 overrun", ovr_flag, 1);
    cpu_hold = 1'b0;
    #1;
    check("R4 release unit", bus_wr_en, 1);
    check("R4 release addr", bus_wr_addr, 20'hFF300);
    step();
    check("R10 single unit", bus_wr_en, 0);
    check("R10 busy left", busy, 1);
  endtask

  task automatic t_window_s2r();
    load(1'b0, 1'b0, 20'hFFF10, 20'hFFEDF, 8'd2);
    pulse();
    check("R7 top byte ok", bus_wr_en, 1);
    step();
    check("R7 no err yet", err_flag, 0);
    pulse();
    check("R7 bank read", bus_rd_en, 1);
    check("R7 bank dropped", bus_wr_en, 0);
    step();
    check("R7 err set", err_flag, 1);
    load(1'b0, 1'b1, 20'hFFF10, 20'hFFEDF, 8'd1);
    check("R11 err cleared", err_flag, 0);
    pulse();
    check("R7 straddle dropped", bus_wr_en, 0);
    step();
  endtask

  task automatic t_window_r2s();
    load(1'b1, 1'b0, 20'hFFF40, 20'hFEEFF, 8'd1);
    pulse();
    check("R8 no read", bus_rd_en, 0);
    check("R8 sfr written", bus_wr_en, 1);
    check("R8 sfr addr", bus_wr_addr, 20'hFFF40);
    check("R8 byte filler", bus_wr_data, 16'h00A5);
    step();
    check("R8 err", err_flag, 1);
    load(1'b1, 1'b1, 20'hFFF40, 20'hFFEE0, 8'd1);
    pulse();
    check("R8 word filler", bus_wr_data, 16'hA5A5);
    step();
  endtask

  task automatic t_stop();
    load(1'b0, 1'b0, 20'hFFF10, 20'hFF400, 8'd3);
    pulse();
    check("R9 pre-stop unit", bus_wr_en, 1);
    step();
    pwr_state = 2'd2;
    step();
    check("R9 busy cleared", busy, 0);
    check("R9 abort set", abort_flag, 1);
    pulse();
    check("R9 no read in stop", bus_rd_en, 0);
    check("R9 no write in stop", bus_wr_en, 0);
    step();
    check("R9 no done", done_irq, 0);
    pwr_state = 2'd0;
    step();
    check("R9 stays idle", bus_wr_en, 0);
    load(1'b0, 1'b0, 20'hFFF10, 20'hFF500, 8'd1);
    check("R11 abort cleared", abort_flag, 0);
    check("R11 ovr cleared", ovr_flag, 0);
    check("R11 pend dropped", bus_wr_en, 0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_byte_s2r();
    t_word_r2s();
    t_halt();
    t_hold();
    t_window_s2r();
    t_window_r2s();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule